// File: doc/BRIEF.md
# Channel Status and Interrupt Register

This block keeps the sticky event flags and the interrupt request of one channel in a serial media bus channel controller. A channel engine feeds it single-cycle strobes: one when the first quadlet of a buffer has moved, one when the last quadlet has moved, and a command byte with a valid strobe for each command byte the channel receives or observes on the bus. A mode input chooses between DMA and IO meaning for the flags. A direction input tells a transmit channel from a receive channel, and a type input gives the channel class: control, async, synchronous or isochronous.

Software reaches the block through a simple write port. A select line picks the status word or the control word. Status flags are cleared by writing 1 to them. The control word holds a start bit and one interrupt enable per flag. In DMA mode with ping-pong buffering, hardware clears the start bit when the engine reports that buffer processing has begun. In circular buffering the start bit stays set until software clears it. The read side shows the status and control words directly. One registered, active-high interrupt output is raised while any enabled flag is set.

Top module: `chs_status_top`

## Requirements
- R1: Status bits 15:12 and 8:0 always read zero and writes cannot change them. Control bits 15:4 always read zero.
- R2: In DMA mode, a pulse on first_q_i sets status bit 11 at the next clock edge.
- R3: In DMA mode, a pulse on last_q_i sets status bit 10 at the next clock edge.
- R4: In DMA mode, a valid command byte sets status bit 9 in two cases: on a transmit channel when the byte is 0x70, and on a receive channel when the byte is 0x36 or 0x26. Channel type plays no part. Any other byte leaves bit 9 unchanged.
- R5: In IO mode, a valid command byte of 0x30 or 0x20 on a receive channel sets status bit 9, but only when ch_type_i is 0 (control) or 1 (async). Types 2 (synchronous), 3 (isochronous), transmit channels and all other bytes leave bit 9 unchanged.
- R6: In IO mode, first_q_i and last_q_i have no effect, so bits 11 and 10 stay zero.
- R7: Flags are sticky. A status write (wr_sel_i=0) with a 1 in a flag's position clears that flag. A 0 in that position leaves it unchanged.
- R8: If a set event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R9: irq_o is a register. It is loaded each cycle with the OR of status bits 11, 10 and 9, each ANDed with its enable in control bits 3, 2 and 1. It therefore follows one cycle after the flags and enables.
- R10: Control bit 0 is the start bit, written through a control write (wr_sel_i=1). In DMA mode with ping_pong_i=1, a buf_begin_i pulse clears it at the next edge. With ping_pong_i=0 it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_mode_i | input | 1 | 1 = DMA meaning, 0 = IO meaning |
| dir_tx_i | input | 1 | 1 = transmit channel, 0 = receive channel |
| ch_type_i | input | 2 | 0 control, 1 async, 2 synchronous, 3 isochronous |
| ping_pong_i | input | 1 | 1 = ping-pong buffering, 0 = circular |
| first_q_i | input | 1 | First quadlet of buffer transferred |
| last_q_i | input | 1 | Last quadlet of buffer transferred |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_byte_i | input | 8 | Observed command byte |
| buf_begin_i | input | 1 | Buffer processing has begun |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 1 | 0 = status word, 1 = control word |
| wr_data_i | input | 16 | Write data |
| status_o | output | 16 | Status word |
| control_o | output | 16 | Control word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every one of the 256 command byte values is applied under each combination of mode, direction and channel type. This separates break decoding from packet-start decoding, separates the transmit code from the receive codes, and shows that the type gate acts only in IO mode. The quadlet strobes are tried in both modes, alone and together, so that bits 10 and 11 are shown to be independent and blocked in IO mode. All eight flag patterns are crossed with all eight enable patterns, which exposes any enable tied to the wrong flag. Start-bit clearing is tried with both buffering schemes.

// File: rtl/chs_pkg.sv
package chs_pkg;
  typedef enum logic [1:0] {
    CH_CTRL  = 2'd0,
    CH_ASYNC = 2'd1,
    CH_SYNC  = 2'd2,
    CH_ISOC  = 2'd3
  } ch_type_e;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_RCV_BREAK  = 8'h70;
  localparam logic [CMD_W-1:0] CMD_CTL_BREAK  = 8'h36;
  localparam logic [CMD_W-1:0] CMD_ASY_BREAK  = 8'h26;
  localparam logic [CMD_W-1:0] CMD_CTL_START  = 8'h30;
  localparam logic [CMD_W-1:0] CMD_ASY_START  = 8'h20;

  // flag index within the flag vector
  localparam int FLG_EVT   = 0;
  localparam int FLG_DONE  = 1;
  localparam int FLG_START = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/chs_cmd_decode.sv
module chs_cmd_decode
  import chs_pkg::*;
(
  input  logic             dma_mode_i,
  input  logic             dir_tx_i,
  input  logic [1:0]       ch_type_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_byte_i,
  output logic             hit_o
);
  ch_type_e ch_type;
  logic     brk_tx, brk_rx, pkt_start, type_ok;

  always_comb begin
    ch_type   = ch_type_e'(ch_type_i);
    brk_tx    = (cmd_byte_i == CMD_RCV_BREAK);
    brk_rx    = (cmd_byte_i == CMD_CTL_BREAK) || (cmd_byte_i == CMD_ASY_BREAK);
    pkt_start = (cmd_byte_i == CMD_CTL_START) || (cmd_byte_i == CMD_ASY_START);
    type_ok   = (ch_type == CH_CTRL) || (ch_type == CH_ASYNC);
    hit_o     = 1'b0;
    if (cmd_valid_i) begin
      if (dma_mode_i) hit_o = dir_tx_i ? brk_tx : brk_rx;
      else            hit_o = !dir_tx_i && type_ok && pkt_start;
    end
  end
endmodule

// File: rtl/chs_flag_cell.sv
module chs_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/chs_ctrl_reg.sv
module chs_ctrl_reg #(
  parameter int NUM_FLAGS = 3,
  localparam int CTRL_W = NUM_FLAGS + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [CTRL_W-1:0]    wr_data_i,
  input  logic                 hw_clr_start_i,
  output logic                 start_o,
  output logic [NUM_FLAGS-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      mask_o  <= '0;
    end else if (wr_i) begin
      start_o <= wr_data_i[0];
      mask_o  <= wr_data_i[CTRL_W-1:1];
    end else if (hw_clr_start_i) begin
      start_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chs_status_top.sv
module chs_status_top
  import chs_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FLAG_LSB = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_mode_i,
  input  logic              dir_tx_i,
  input  logic [1:0]        ch_type_i,
  input  logic              ping_pong_i,
  input  logic              first_q_i,
  input  logic              last_q_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_byte_i,
  input  logic              buf_begin_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  control_o,
  output logic              irq_o
);
  localparam int CTRL_W = NUM_FLAGS + 1;

  logic                 cmd_hit;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags, mask;
  logic                 start, wr_status, wr_ctrl, hw_clr_start;
  logic                 unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign wr_status    = wr_en_i && !wr_sel_i;
  assign wr_ctrl      = wr_en_i && wr_sel_i;

  chs_cmd_decode i_dec (
    .dma_mode_i (dma_mode_i),
    .dir_tx_i   (dir_tx_i),
    .ch_type_i  (ch_type_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i (cmd_byte_i),
    .hit_o      (cmd_hit)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_START] = dma_mode_i && first_q_i;
    flag_set[FLG_DONE]  = dma_mode_i && last_q_i;
    flag_set[FLG_EVT]   = cmd_hit;
    flag_clr            = {NUM_FLAGS{wr_status}} & wr_data_i[FLAG_LSB +: NUM_FLAGS];
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    chs_flag_cell i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .flag_o(flags[g])
    );
  end

  assign hw_clr_start = dma_mode_i && ping_pong_i && buf_begin_i && start;

  chs_ctrl_reg #(.NUM_FLAGS(NUM_FLAGS)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_ctrl),
    .wr_data_i     (wr_data_i[CTRL_W-1:0]),
    .hw_clr_start_i(hw_clr_start),
    .start_o       (start),
    .mask_o        (mask)
  );

  always_comb begin
    status_o                           = '0;
    status_o[FLAG_LSB +: NUM_FLAGS]    = flags;
    control_o                          = '0;
    control_o[CTRL_W-1:0]              = {mask, start};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags & mask);
  end
endmodule

// File: rtl/chs_checker.sv
module chs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dma_mode_i,
  input logic        ping_pong_i,
  input logic        buf_begin_i,
  input logic        first_q_i,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] status_o,
  input logic [15:0] control_o,
  input logic        irq_o
);
  logic unused_wd;
  assign unused_wd = ^{wr_data_i[15:12], wr_data_i[10], wr_data_i[8:1]};

  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:12] == 4'd0 && status_o[8:0] == 9'd0 && control_o[15:4] == 12'd0);

  assert_first_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && first_q_i |=> status_o[11]);

  assert_io_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_mode_i && !status_o[10] |=> !status_o[10]);

  assert_sticky_11_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[11] && !(wr_en_i && !wr_sel_i && wr_data_i[11]) |=> status_o[11]);

  assert_sticky_9_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[9] && !(wr_en_i && !wr_sel_i && wr_data_i[9]) |=> status_o[9]);

  assert_irq_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(status_o[11:9] & control_o[3:1]) |=> irq_o);

  assert_irq_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_o[11:9] & control_o[3:1])) |=> !irq_o);

  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && ping_pong_i && buf_begin_i && !(wr_en_i && wr_sel_i) |=> !control_o[0]);

  assert_start_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    control_o[0] && !ping_pong_i && !(wr_en_i && wr_sel_i) |=> control_o[0]);
endmodule

bind chs_status_top chs_checker i_chk (.*);

// File: tb/test_chs_status_top.sv
module test_chs_status_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dma_mode_i = 1'b0, dir_tx_i = 1'b0, ping_pong_i = 1'b0;
  logic [1:0]  ch_type_i = 2'd0;
  logic        first_q_i = 1'b0, last_q_i = 1'b0, cmd_valid_i = 1'b0, buf_begin_i = 1'b0;
  logic [7:0]  cmd_byte_i = 8'd0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = 16'd0;
  logic [15:0] status_o, control_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  chs_status_top i_chs_status_top (.*);

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = 16'd0;
  endtask

  function automatic bit exp9(bit dma, bit tx, int ty, int b);
    if (dma) return tx ? (b == 'h70) : (b == 'h36 || b == 'h26);
    return !tx && ty < 2 && (b == 'h30 || b == 'h20);
  endfunction

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    check(status_o == 16'h0, "R1 reset status", status_o, 0);
    check(control_o == 16'h0 && irq_o == 1'b0, "R9 reset ctrl/irq", control_o, 0);

    // R1: reserved bits
    wr(1'b0, 16'hFFFF);
    check(status_o == 16'h0, "R1 status write", status_o, 0);
    wr(1'b1, 16'hFFFF);
    check(control_o == 16'h000F, "R1 control write", control_o, 'hF);
    wr(1'b1, 16'h0000);

    // R4/R5: sweep command bytes over mode, direction, type
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int t = 0; t < 4; t++)
          for (int b = 0; b < 256; b++) begin
            wr(1'b0, 16'hFFFF);
            dma_mode_i = m[0]; dir_tx_i = d[0]; ch_type_i = t[1:0];
            cmd_valid_i = 1'b1; cmd_byte_i = b[7:0];
            tick();
            cmd_valid_i = 1'b0;
            check(status_o[9] == exp9(m[0], d[0], t, b) && status_o[11:10] == 2'b00,
                  m ? "R4 break decode" : "R5 start decode",
                  status_o, int'(exp9(m[0], d[0], t, b)) << 9);
          end
    // cmd_valid low: code must not set
    wr(1'b0, 16'hFFFF);
    dma_mode_i = 1'b1; dir_tx_i = 1'b1; cmd_byte_i = 8'h70;
    tick();
    check(status_o[9] == 1'b0, "R4 no valid", status_o, 0);

    // R2/R3/R6: quadlet strobes
    for (int m = 0; m < 2; m++)
      for (int p = 1; p < 4; p++) begin
        wr(1'b0, 16'hFFFF);
        dma_mode_i = m[0]; first_q_i = p[1]; last_q_i = p[0];
        tick();
        first_q_i = 1'b0; last_q_i = 1'b0;
        check(status_o == (m ? (p << 10) : 0), m ? "R2 R3 quadlet flags" : "R6 io ignores quadlet",
              status_o, m ? (p << 10) : 0);
      end

    // R7: sticky, write 0 no effect, write 1 clears one flag
    dma_mode_i = 1'b1; dir_tx_i = 1'b1;
    first_q_i = 1'b1; last_q_i = 1'b1; cmd_valid_i = 1'b1; cmd_byte_i = 8'h70;
    tick();
    first_q_i = 1'b0; last_q_i = 1'b0; cmd_valid_i = 1'b0;
    repeat (3) tick();
    check(status_o == 16'h0E00, "R7 sticky", status_o, 'hE00);
    wr(1'b0, 16'h0000);
    check(status_o == 16'h0E00, "R7 write zero", status_o, 'hE00);
    wr(1'b0, 16'h0400);
    check(status_o == 16'h0A00, "R7 clear bit10", status_o, 'hA00);

    // R8: set wins over clear in the same cycle
    first_q_i = 1'b1;
    wr(1'b0, 16'h0800);
    first_q_i = 1'b0;
    check(status_o[11] == 1'b1, "R8 set wins", status_o, 'hA00);
    wr(1'b0, 16'hFFFF);
    check(status_o == 16'h0, "R7 clear all", status_o, 0);

    // R9: all flag patterns x all mask patterns
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 8; k++) begin
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'hFFFF);
        dma_mode_i = 1'b1; dir_tx_i = 1'b1;
        first_q_i = f[2]; last_q_i = f[1]; cmd_valid_i = f[0]; cmd_byte_i = 8'h70;
        tick();
        first_q_i = 1'b0; last_q_i = 1'b0; cmd_valid_i = 1'b0;
        wr(1'b1, 16'(k << 1));
        tick();
        check(irq_o == ((f & k) != 0), "R9 irq mask", irq_o, int'((f & k) != 0));
      end
    // R9: irq lags by one cycle
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'hFFFF);
    wr(1'b1, 16'h0008);
    first_q_i = 1'b1;
    tick();
    first_q_i = 1'b0;
    check(irq_o == 1'b0, "R9 irq registered", irq_o, 0);
    tick();
    check(irq_o == 1'b1, "R9 irq follows", irq_o, 1);
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'hFFFF);

    // R10: start bit with ping-pong and circular
    dma_mode_i = 1'b1; ping_pong_i = 1'b1;
    wr(1'b1, 16'h0001);
    check(control_o[0] == 1'b1, "R10 start set", control_o, 1);
    buf_begin_i = 1'b1;
    tick();
    buf_begin_i = 1'b0;
    check(control_o[0] == 1'b0, "R10 ping-pong clear", control_o, 0);
    ping_pong_i = 1'b0;
    wr(1'b1, 16'h0001);
    buf_begin_i = 1'b1;
    tick();
    buf_begin_i = 1'b0;
    tick();
    check(control_o[0] == 1'b1, "R10 circular hold", control_o, 1);
    wr(1'b1, 16'h0000);
    check(control_o[0] == 1'b0, "R10 software clear", control_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule